// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small user-configurable logic array. Eight dedicated inputs and eight bidirectional pins feed a programmable AND plane of product terms, and a programmable OR plane adds any chosen set of those terms for each of eight output cells. Each output cell can invert its sum. It can either drive the pin directly or pass the value through a flip-flop clocked by `clk`. The flip-flop output feeds back into the AND plane, so the array can implement state machines as well as plain combinational functions.

The array is set up through a serial bit stream. Bits are shifted in on `cfg_clk` while `cfg_load` is high. The array keeps running on its previous settings until the load window closes, and then the whole new image is applied at once. An output cell that is not set to drive its pin leaves the pin high-impedance. The value on such a pin then acts as an extra input to the AND plane.

Top module: `sop_logic_array`

## Requirements
- R1: The AND plane has 16 variables: variable v < 8 is `din[v]`, and variable 8+k is the feedback of output cell k. Literal 2v is the true form of variable v and literal 2v+1 is its complement. Product term t is the AND of every literal whose selection bit is set; configuration bit t*32 + literal selects that literal for term t (terms 0..31).
- R2: A product term with no literal selected evaluates to 1.
- R3: Output cell o sums (ORs) every product term t whose bit 1024 + o*32 + t is set. A cell with no term selected sums to 0.
- R4: Each output cell k has three control bits at 1280 + 3k: bit +0 selects registered mode, bit +1 inverts the sum, and bit +2 lets the cell drive its pin. When the invert bit is set, the cell's value is the complement of its sum, in both modes.
- R5: In combinational mode with drive set, the pin shows the cell's value in the same cycle, with no clock edge in between.
- R6: In registered mode, the cell's flip-flop takes the value at each rising `clk` edge, the pin shows the flip-flop, and the feedback variable is the flip-flop. This allows a counter to be built from the array.
- R7: A registered cell drives its pin only while `oe` is high, and its flip-flop keeps counting while the pin is released. `oe` has no effect on combinational cells.
- R8: A cell whose drive bit is clear leaves its pin high-impedance. In combinational mode, that cell's feedback variable is the value present on the pin.
- R9: The configuration is 1304 bits, shifted LSB-first: each rising `cfg_clk` edge with `cfg_load` high takes `cfg_data`. The new image becomes active at the first rising `cfg_clk` edge at which `cfg_load` is low after it was high at the edge before.
- R10: While `cfg_load` is high, the active configuration does not change, so the array keeps working on the previous settings.
- R11: Reset (`rst_n` low) clears every flip-flop and the whole configuration, so all pins are high-impedance after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output-cell flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset for flip-flops and configuration |
| oe | input | 1 | Pin enable for registered output cells |
| din | input | 8 | Dedicated inputs to the AND plane |
| io_pins | inout | 8 | Bidirectional pins, one per output cell |
| cfg_clk | input | 1 | Shift clock for the configuration stream |
| cfg_load | input | 1 | High while configuration bits are being shifted |
| cfg_data | input | 1 | Serial configuration bit |

## Verification
The assertions check the configuration store and the output cells on every cycle. They confirm that the shift register takes each serial bit, that the active image is frozen while loading and copied when the window closes, that a registered cell captures its value at every clock, and that a registered cell never drives its pin while `oe` is low. The sum-of-products function itself, including the literal polarities, empty terms and empty sums, and feedback from undriven pins, can only be shown by the bench. The bench compares every dedicated-input pattern under several configurations against an independent model. It also checks that the registered counter keeps counting while its pins are released and while a new image is being shifted in.

// File: rtl/sop_pkg.sv
package sop_pkg;

    // Per-output-cell control field; the first member listed is the MSB.
    typedef struct packed {
        logic drive;   // bit 2: cell may drive its pin
        logic invert;  // bit 1: complement the sum
        logic regd;    // bit 0: registered mode
    } mc_cfg_t;

    localparam int MC_W = $bits(mc_cfg_t);

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int CFG_BITS = 1304
) (
    input  logic                cfg_clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic                cfg_data,
    output logic [CFG_BITS-1:0] cfg_active
);

    typedef struct packed {
        logic [CFG_BITS-1:0] shift;
        logic                load;
        logic [CFG_BITS-1:0] active;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.load = cfg_load;
        if (cfg_load) begin
            st_d.shift = {cfg_data, st_q.shift[CFG_BITS-1:1]};
        end
        if (st_q.load && !cfg_load) begin
            st_d.active = st_q.shift;
        end
    end

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_active = st_q.active;

    // R9: the serial bit enters at the top of the shift register
    assert_shift_in_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_load |=> st_q.shift[CFG_BITS-1] == $past(cfg_data));

    // R9: closing the load window copies the shifted image
    assert_apply_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (st_q.load && !cfg_load) |=> st_q.active == $past(st_q.shift));

    // R10: no change of the active image while loading
    assert_hold_R10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        cfg_load |=> $stable(st_q.active));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_VAR = 16,
    parameter int N_PT  = 32
) (
    input  logic [N_VAR-1:0]        vars,
    input  logic [N_PT*2*N_VAR-1:0] sel,
    output logic [N_PT-1:0]         terms
);

    localparam int N_LIT = 2 * N_VAR;

    logic [N_LIT-1:0] lits;

    // Even literal = true form, odd literal = complement.
    always_comb begin
        for (int v = 0; v < N_VAR; v++) begin
            lits[2*v]   = vars[v];
            lits[2*v+1] = ~vars[v];
        end
    end

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        // An unselected literal counts as 1, so an empty term is 1.
        assign terms[t] = &(~sel[t*N_LIT +: N_LIT] | lits);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_PT = 32,
    parameter int N_MC = 8
) (
    input  logic [N_PT-1:0]      terms,
    input  logic [N_MC*N_PT-1:0] sel,
    output logic [N_MC-1:0]      sums
);

    for (genvar o = 0; o < N_MC; o++) begin : g_sum
        assign sums[o] = |(terms & sel[o*N_PT +: N_PT]);
    end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    oe,
    input  logic    sum,
    input  mc_cfg_t mcfg,
    input  logic    pin_in,
    output logic    pin_out,
    output logic    pin_oe,
    output logic    fb
);

    typedef struct packed {
        logic q;
    } cell_t;

    cell_t cell_d, cell_q;
    logic  value;

    always_comb begin
        value    = sum ^ mcfg.invert;
        cell_d   = cell_q;
        // Combinational mode keeps the flop cleared so that a later
        // switch to registered mode starts from 0.
        cell_d.q = mcfg.regd ? value : 1'b0;
        pin_out  = mcfg.regd ? cell_q.q : value;
        pin_oe   = mcfg.drive & (~mcfg.regd | oe);
        fb       = mcfg.regd ? cell_q.q : pin_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    // R6: a registered cell captures its value at each edge
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mcfg.regd) |-> cell_q.q == $past(value));

    // R7: a registered cell releases its pin while oe is low
    always_comb begin
        if (rst_n && mcfg.regd && !oe) begin
            assert_release_R7: assert (!pin_oe) else $error("registered pin driven with oe low");
        end
    end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
    import sop_pkg::*;
#(
    parameter int N_DED = 8,
    parameter int N_MC  = 8,
    parameter int N_PT  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe,
    input  logic [N_DED-1:0] din,
    inout  wire  [N_MC-1:0]  io_pins,
    input  logic             cfg_clk,
    input  logic             cfg_load,
    input  logic             cfg_data
);

    localparam int N_VAR    = N_DED + N_MC;
    localparam int N_LIT    = 2 * N_VAR;
    localparam int AND_BITS = N_PT * N_LIT;
    localparam int OR_BITS  = N_MC * N_PT;
    localparam int MCB_BITS = N_MC * MC_W;
    localparam int CFG_BITS = AND_BITS + OR_BITS + MCB_BITS;

    logic [CFG_BITS-1:0] cfg;
    logic [N_PT-1:0]     terms;
    logic [N_MC-1:0]     sums;
    logic [N_MC-1:0]     fb;
    logic [N_MC-1:0]     pin_out;
    logic [N_MC-1:0]     pin_oe;

    sop_cfg_store #(.CFG_BITS(CFG_BITS)) u_cfg (
        .cfg_clk    (cfg_clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_data   (cfg_data),
        .cfg_active (cfg)
    );

    sop_and_plane #(.N_VAR(N_VAR), .N_PT(N_PT)) u_and (
        .vars  ({fb, din}),
        .sel   (cfg[AND_BITS-1:0]),
        .terms (terms)
    );

    sop_or_plane #(.N_PT(N_PT), .N_MC(N_MC)) u_or (
        .terms (terms),
        .sel   (cfg[AND_BITS +: OR_BITS]),
        .sums  (sums)
    );

    for (genvar g = 0; g < N_MC; g++) begin : g_cell
        sop_macrocell u_mc (
            .clk     (clk),
            .rst_n   (rst_n),
            .oe      (oe),
            .sum     (sums[g]),
            .mcfg    (mc_cfg_t'(cfg[AND_BITS + OR_BITS + g*MC_W +: MC_W])),
            .pin_in  (io_pins[g]),
            .pin_out (pin_out[g]),
            .pin_oe  (pin_oe[g]),
            .fb      (fb[g])
        );
        assign io_pins[g] = pin_oe[g] ? pin_out[g] : 1'bz;
    end

endmodule

// File: tb/sim_sop_logic_array.sv
module sim_sop_logic_array;

    localparam int N_VAR    = 16;
    localparam int N_PT     = 32;
    localparam int N_LIT    = 32;
    localparam int OR_BASE  = 1024;
    localparam int MC_BASE  = 1280;
    localparam int CFG_BITS = 1304;

    logic       clk = 1'b0;
    logic       rst_n, oe, cfg_clk, cfg_load, cfg_data;
    logic [7:0] din, tb_val, tb_en;
    tri   [7:0] io_pins;

    int errors = 0;
    int checks = 0;

    logic [CFG_BITS-1:0] img, cur;

    always #4 clk = ~clk;

    for (genvar g = 0; g < 8; g++) begin : g_drv
        assign io_pins[g] = tb_en[g] ? tb_val[g] : 1'bz;
    end
    pullup (io_pins[0]);
    pullup (io_pins[1]);
    pullup (io_pins[2]);
    pullup (io_pins[3]);
    pullup (io_pins[4]);
    pullup (io_pins[5]);
    pullup (io_pins[6]);
    pullup (io_pins[7]);

    sop_logic_array u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe       (oe),
        .din      (din),
        .io_pins  (io_pins),
        .cfg_clk  (cfg_clk),
        .cfg_load (cfg_load),
        .cfg_data (cfg_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_lit(input int t, input int v, input bit neg);
        img[t*N_LIT + 2*v + (neg ? 1 : 0)] = 1'b1;
    endtask

    task automatic set_or(input int o, input int t);
        img[OR_BASE + o*N_PT + t] = 1'b1;
    endtask

    task automatic set_mc(input int o, input bit regd, input bit inv, input bit drv);
        img[MC_BASE + 3*o]     = regd;
        img[MC_BASE + 3*o + 1] = inv;
        img[MC_BASE + 3*o + 2] = drv;
    endtask

    // Shift the image LSB-first, then one edge with load low to apply it.
    task automatic load_cfg();
        logic [CFG_BITS-1:0] snap;
        snap = img;
        cfg_load = 1'b1;
        for (int i = 0; i < CFG_BITS; i++) begin
            cfg_data = snap[i];
            #4 cfg_clk = 1'b1;
            #4 cfg_clk = 1'b0;
        end
        cfg_load = 1'b0;
        #4 cfg_clk = 1'b1;
        #4 cfg_clk = 1'b0;
        cur = snap;
    endtask

    // Independent evaluation of the cell values for combinational cells.
    function automatic logic [7:0] model(input logic [CFG_BITS-1:0] c,
                                         input logic [7:0] d, input logic [7:0] p);
        logic [N_VAR-1:0] vars;
        logic [N_PT-1:0]  pt;
        logic [7:0]       res;
        vars = {p, d};
        for (int t = 0; t < N_PT; t++) begin
            pt[t] = 1'b1;
            for (int v = 0; v < N_VAR; v++) begin
                if (c[t*N_LIT + 2*v] && !vars[v])    pt[t] = 1'b0;
                if (c[t*N_LIT + 2*v + 1] && vars[v]) pt[t] = 1'b0;
            end
        end
        for (int o = 0; o < 8; o++) begin
            res[o] = 1'b0;
            for (int t = 0; t < N_PT; t++) begin
                if (c[OR_BASE + o*N_PT + t] && pt[t]) res[o] = 1'b1;
            end
            res[o] = res[o] ^ c[MC_BASE + 3*o + 1];
        end
        return res;
    endfunction

    // Random combinational image; cells 0..3 drive, 4..7 are pin inputs.
    task automatic make_comb(input bit variant);
        img = '0;
        for (int t = 0; t < N_PT - 1; t++) begin
            for (int v = 0; v < N_VAR; v++) begin
                if (v < 8 || v >= 12) begin
                    int r;
                    r = int'($urandom % 8);
                    if (r == 0) set_lit(t, v, 1'b0);
                    if (r == 1) set_lit(t, v, 1'b1);
                end
            end
        end
        set_or(0, N_PT - 1);               // empty term only
        for (int t = 0; t < N_PT - 1; t++) begin
            if ($urandom % 4 == 0) set_or(1, t);
            if ($urandom % 4 == 0) set_or(2, t);
        end
        set_mc(0, 1'b0, variant, 1'b1);
        set_mc(1, 1'b0, 1'b1, 1'b1);
        set_mc(2, 1'b0, 1'b0, 1'b1);
        set_mc(3, 1'b0, variant, 1'b1);    // no terms: sum is 0
    endtask

    task automatic sweep();
        logic [7:0] expv, first;
        for (int d = 0; d < 256; d++) begin
            din          = 8'(d);
            tb_val[7:4]  = 4'($urandom);
            oe           = 1'($urandom);
            #2;
            expv = model(cur, din, io_pins);
            chk("R2 empty term on pin 0", 32'(io_pins[0]), 32'(expv[0]));
            chk("R4 inverted pin 1", 32'(io_pins[1]), 32'(expv[1]));
            chk("R1/R5 product sum on pin 2", 32'(io_pins[2]), 32'(expv[2]));
            chk("R3 empty sum on pin 3", 32'(io_pins[3]), 32'(expv[3]));
            chk("R8 undriven pins carry input", 32'(io_pins[7:4]), 32'(tb_val[7:4]));
            first = io_pins;
            oe = ~oe;
            #1;
            chk("R7 oe ignored by combinational cells", 32'(io_pins[3:0]), 32'(first[3:0]));
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0] v0;
        bit found;
        void'($urandom(32'h5eed1234));
        rst_n = 1'b0; oe = 1'b0; din = '0; cfg_clk = 1'b0;
        cfg_load = 1'b0; cfg_data = 1'b0; tb_en = '0; tb_val = '0;
        img = '0; cur = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 all pins released after reset", 32'(io_pins), 32'hff);

        // 3-bit counter on cells 0..2, constant-1 registered cell 4.
        img = '0;
        set_lit(0, 8, 1'b1);                                set_or(0, 0);
        set_lit(1, 9, 1'b0); set_lit(1, 8, 1'b1);           set_or(1, 1);
        set_lit(2, 9, 1'b1); set_lit(2, 8, 1'b0);           set_or(1, 2);
        set_lit(3, 10, 1'b0); set_lit(3, 9, 1'b1);          set_or(2, 3);
        set_lit(4, 10, 1'b0); set_lit(4, 8, 1'b1);          set_or(2, 4);
        set_lit(5, 10, 1'b1); set_lit(5, 9, 1'b0); set_lit(5, 8, 1'b0); set_or(2, 5);
        set_mc(0, 1'b1, 1'b0, 1'b1);
        set_mc(1, 1'b1, 1'b0, 1'b1);
        set_mc(2, 1'b1, 1'b0, 1'b1);
        set_mc(4, 1'b1, 1'b1, 1'b1);
        oe = 1'b1;
        load_cfg();
        repeat (3) @(negedge clk);
        v0 = io_pins[2:0];
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R6/R9 registered counter step", 32'(io_pins[2:0]), 32'(3'(v0 + k)));
        end
        chk("R4 inverted empty sum in registered cell", 32'(io_pins[4]), 32'h1);
        chk("R8 cells without drive stay released", 32'({io_pins[7:5], io_pins[3]}), 32'hf);

        found = 1'b0;
        for (int k = 0; k < 10 && !found; k++) begin
            @(negedge clk);
            if (io_pins[2:0] == 3'd7) found = 1'b1;
        end
        chk("R6 counter reaches 7", 32'(found), 32'h1);
        oe = 1'b0;
        @(negedge clk);
        chk("R7 registered pins released with oe low", 32'(io_pins), 32'hff);
        repeat (4) @(negedge clk);
        oe = 1'b1;
        #1;
        chk("R7 counter advanced while released", 32'(io_pins[2:0]), 32'h4);

        // New image shifted while the counter keeps running.
        make_comb(1'b0);
        @(negedge clk);
        fork
            load_cfg();
        join_none
        repeat (2) @(negedge clk);
        v0 = io_pins[2:0];
        repeat (5) @(negedge clk);
        chk("R10 old settings active during load", 32'(io_pins[2:0]), 32'(3'(v0 + 5)));
        wait fork;
        tb_en = 8'hf0;
        sweep();

        make_comb(1'b1);
        load_cfg();
        sweep();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule